// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel that copies data between two memory regions. Software presents a source address, a destination address, a transfer count and a set of control fields, and latches them with a load strobe. It then raises the channel enable. While the channel is enabled and its end flag is clear, it asks an outside arbiter for the bus. Once the grant arrives it moves one unit per transfer over a valid/ready memory port: it reads the unit, then writes it.

After each unit the source and destination addresses move according to their own mode (held, stepped up or stepped down by the unit size), and the count drops by one. When the count runs out the channel sets an end flag and, if interrupts are enabled, an interrupt. In cycle-steal mode the channel gives the bus back for one cycle after every unit. In burst mode it keeps the bus until the whole count is done.

Top module: `dma_chan_engine`

## Requirements
- R1: Out of reset, `bus_req_o`, `mem_valid_o`, `end_flag_o` and `irq_o` are all low.
- R2: The channel raises `bus_req_o` only while `enable_i` is high and the end flag is clear. It starts no memory access until it sees `grant_i` high while waiting.
- R3: Each transfer reads the whole unit and then writes it, and every written beat carries the data returned by the matching read beat. A 16-byte unit is four 32-bit beats at unit base +0, +4, +8, +12 and counts as one transfer. Smaller units are a single beat.
- R4: The source mode and destination mode are separate 2-bit codes: 0 holds the address, 1 adds the unit size after each transfer, 2 subtracts it, and 3 behaves as 0.
- R5: The unit code selects the size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 16 bytes. `mem_size_o` shows the beat size as log2 of its bytes, so it equals the unit code, or 2 for 16-byte units.
- R6: The count is CNT_W bits wide, and a loaded value of 0 performs 2^CNT_W transfers.
- R7: With `burst_i` = 0 (cycle-steal), `bus_req_o` drops for one cycle after every unit that is not the last.
- R8: With `burst_i` = 1, `bus_req_o` stays high from the first grant until the count is exhausted.
- R9: The end flag rises in the cycle after the final write beat is accepted. `irq_o` is high exactly when the end flag is set and the latched interrupt enable was 1.
- R10: While the end flag is set, the channel makes no requests and no accesses, even with `enable_i` high and a new count loaded. A one-cycle `end_clr_i` pulse clears the flag and lets it restart.
- R11: Once `mem_valid_o` is raised, it stays high with unchanged address and direction until `mem_ready_i` accepts the beat.
- R12: `mem_valid_o` is high only while `bus_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Latch addresses, count and control fields (taken while idle) |
| src_addr_i | input | AW | Source start address |
| dst_addr_i | input | AW | Destination start address |
| count_i | input | CNT_W | Transfer count, 0 means 2^CNT_W |
| src_mode_i | input | 2 | Source address mode |
| dst_mode_i | input | 2 | Destination address mode |
| unit_i | input | 2 | Unit size code |
| burst_i | input | 1 | 1 burst, 0 cycle-steal |
| irq_en_i | input | 1 | Interrupt enable |
| enable_i | input | 1 | Channel enable |
| end_clr_i | input | 1 | Clear end flag and interrupt |
| grant_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request to the arbiter |
| mem_valid_o | output | 1 | Memory beat valid |
| mem_write_o | output | 1 | 1 write beat, 0 read beat |
| mem_addr_o | output | AW | Beat byte address |
| mem_size_o | output | 2 | log2 of beat bytes |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_rdata_i | input | DW | Read data, valid with an accepted read beat |
| end_flag_o | output | 1 | Transfer end flag |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the engine with AW = 16, DW = 32 and CNT_W = 4. The narrow counter makes a loaded zero mean only 16 transfers, so the wrap case is checked completely rather than left unreachable. The 16-bit address space with a small word memory keeps stepped-down addresses and 16-byte units inside the modelled region. The memory stalls one cycle in three, so the hold-until-ready behaviour is exercised on every run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_UP   = 2'd1,
    AM_DOWN = 2'd2,
    AM_RSVD = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    UNIT_1  = 2'd0,
    UNIT_2  = 2'd1,
    UNIT_4  = 2'd2,
    UNIT_16 = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_REL
  } state_e;

  typedef struct packed {
    addr_mode_e src_mode;
    addr_mode_e dst_mode;
    unit_e      unit;
    logic       burst;
    logic       irq_en;
  } cfg_t;

  function automatic logic [4:0] unit_bytes(unit_e u);
    case (u)
      UNIT_1:  return 5'd1;
      UNIT_2:  return 5'd2;
      UNIT_4:  return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  addr_mode_e    mode_i,
  input  unit_e         unit_i,
  output logic [AW-1:0] next_o
);

  logic [AW-1:0] step;

  assign step = AW'(unit_bytes(unit_i));

  always_comb begin
    case (mode_i)
      AM_UP:   next_o = cur_i + step;
      AM_DOWN: next_o = cur_i - step;
      default: next_o = cur_i;
    endcase
  end

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  // zero wraps to all ones on the first decrement: 2^CNT_W transfers
  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dma_unit_buf.sv
module dma_unit_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  // small unit store, no reset so it maps to distributed RAM
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [AW-1:0]    src_addr_i,
  input  logic [AW-1:0]    dst_addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       src_mode_i,
  input  logic [1:0]       dst_mode_i,
  input  logic [1:0]       unit_i,
  input  logic             burst_i,
  input  logic             irq_en_i,
  input  logic             enable_i,
  input  logic             end_clr_i,
  input  logic             grant_i,
  output logic             bus_req_o,
  output logic             mem_valid_o,
  output logic             mem_write_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [1:0]       mem_size_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             end_flag_o,
  output logic             irq_o
);

  localparam int BEAT_BYTES = DW / 8;
  localparam int SZ_BEAT    = $clog2(BEAT_BYTES);
  localparam int MAX_BEATS  = 16 / BEAT_BYTES;
  localparam int BW         = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  state_e        state_q;
  cfg_t          cfg_q;
  logic [BW-1:0] beat_q;
  logic          end_q;
  logic          irq_q;
  logic [AW-1:0] addr_q  [2];
  logic [AW-1:0] addr_nx [2];
  addr_mode_e    mode_sel [2];

  logic hs;
  logic last_beat;
  logic unit_done;
  logic cnt_last;
  logic idle_load;

  assign idle_load = load_i && (state_q == ST_IDLE);
  assign hs        = mem_valid_o && mem_ready_i;
  assign last_beat = (cfg_q.unit == UNIT_16) ? (beat_q == BW'(MAX_BEATS - 1))
                                             : (beat_q == '0);
  assign unit_done = (state_q == ST_WR) && hs && last_beat;

  // index 0 steps the source, index 1 the destination
  assign mode_sel[0] = cfg_q.src_mode;
  assign mode_sel[1] = cfg_q.dst_mode;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .cur_i  (addr_q[g]),
      .mode_i (mode_sel[g]),
      .unit_i (cfg_q.unit),
      .next_o (addr_nx[g])
    );
  end

  dma_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load_i     (idle_load),
    .load_val_i (count_i),
    .dec_i      (unit_done),
    .last_o     (cnt_last)
  );

  dma_unit_buf #(.DW(DW), .DEPTH(MAX_BEATS)) u_buf (
    .clk     (clk),
    .we_i    ((state_q == ST_RD) && hs),
    .waddr_i (beat_q),
    .wdata_i (mem_rdata_i),
    .raddr_i (beat_q),
    .rdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      beat_q    <= '0;
      end_q     <= 1'b0;
      irq_q     <= 1'b0;
      addr_q[0] <= '0;
      addr_q[1] <= '0;
    end else begin
      if (idle_load) begin
        addr_q[0]      <= src_addr_i;
        addr_q[1]      <= dst_addr_i;
        cfg_q.src_mode <= addr_mode_e'(src_mode_i);
        cfg_q.dst_mode <= addr_mode_e'(dst_mode_i);
        cfg_q.unit     <= unit_e'(unit_i);
        cfg_q.burst    <= burst_i;
        cfg_q.irq_en   <= irq_en_i;
      end
      if (end_clr_i) begin
        end_q <= 1'b0;
        irq_q <= 1'b0;
      end
      case (state_q)
        ST_IDLE: begin
          if (enable_i && !end_q && grant_i) begin
            state_q <= ST_RD;
            beat_q  <= '0;
          end
        end
        ST_RD: begin
          if (hs) begin
            if (last_beat) begin
              state_q <= ST_WR;
              beat_q  <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_WR: begin
          if (hs) begin
            if (!last_beat) begin
              beat_q <= beat_q + 1'b1;
            end else begin
              beat_q    <= '0;
              addr_q[0] <= addr_nx[0];
              addr_q[1] <= addr_nx[1];
              if (cnt_last) begin
                end_q   <= 1'b1;
                irq_q   <= cfg_q.irq_en;
                state_q <= ST_IDLE;
              end else if (cfg_q.burst) begin
                state_q <= enable_i ? ST_RD : ST_IDLE;
              end else begin
                state_q <= ST_REL;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_write_o = (state_q == ST_WR);
  assign mem_addr_o  = ((state_q == ST_WR) ? addr_q[1] : addr_q[0])
                     + (AW'(beat_q) << SZ_BEAT);
  assign mem_size_o  = (cfg_q.unit == UNIT_16) ? 2'(SZ_BEAT) : 2'(cfg_q.unit);
  assign bus_req_o   = mem_valid_o || ((state_q == ST_IDLE) && enable_i && !end_q);
  assign end_flag_o  = end_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic          end_flag,
  input logic          irq,
  input logic          unit_done,
  input logic          burst
);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // R12
  valid_owns_bus_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> bus_req);

  // R10
  ended_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    end_flag |-> !mem_valid);

  // R9
  irq_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> end_flag);

  // R9
  end_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(end_flag) |-> $past(unit_done));

  // R7
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    unit_done && !burst |=> !bus_req);

endmodule

bind dma_chan_engine dma_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req_o),
  .mem_valid (mem_valid_o),
  .mem_ready (mem_ready_i),
  .mem_write (mem_write_o),
  .mem_addr  (mem_addr_o),
  .end_flag  (end_flag_o),
  .irq       (irq_o),
  .unit_done (unit_done),
  .burst     (cfg_q.burst)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

  localparam int AW = 16;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam int NV = 7;
  // {src_mode, dst_mode, unit, burst, irq_en, count}
  localparam logic [11:0] VEC [NV] = '{
    {2'd1, 2'd1, 2'd2, 1'b0, 1'b1, 4'd3},
    {2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 4'd4},
    {2'd2, 2'd2, 2'd1, 1'b0, 1'b1, 4'd3},
    {2'd1, 2'd2, 2'd3, 1'b1, 1'b1, 4'd2},
    {2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 4'd2},
    {2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 4'd5},
    {2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 4'd2}
  };

  logic          clk = 0;
  logic          rst = 1;
  logic          load_i = 0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [1:0]    src_mode_i = '0, dst_mode_i = '0, unit_i = '0;
  logic          burst_i = 0, irq_en_i = 0, enable_i = 0, end_clr_i = 0, grant_i = 1;
  logic          bus_req_o, mem_valid_o, mem_write_o, mem_ready_i = 0;
  logic [AW-1:0] mem_addr_o;
  logic [1:0]    mem_size_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic          end_flag_o, irq_o;

  int total = 0, bad = 0, cyc = 0, stall = 0;
  logic [31:0] mem [256];
  int          log_n = 0, drops = 0;
  logic [15:0] log_addr [64];
  logic        log_wr   [64];
  logic [1:0]  log_size [64];
  logic [31:0] log_data [64];
  logic        prev_req = 0;

  always #5 clk = ~clk;

  dma_chan_engine #(.AW(AW), .CNT_W(CW), .DW(DW)) dut (.*);

  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 stall = stall + 1;
    mem_ready_i = (stall % 3) != 0;
  end

  always @(negedge clk) begin
    if (mem_valid_o && mem_ready_i && log_n < 64) begin
      log_addr[log_n] = mem_addr_o;
      log_wr[log_n]   = mem_write_o;
      log_size[log_n] = mem_size_o;
      log_data[log_n] = mem_write_o ? mem_wdata_o : mem_rdata_i;
      if (mem_write_o) mem[mem_addr_o[9:2]] = mem_wdata_o;
      log_n = log_n + 1;
    end
    if (prev_req && !bus_req_o && !end_flag_o) drops = drops + 1;
    prev_req = bus_req_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input int src, input int dst, input int cnt,
                          input int sm, input int dm, input int un,
                          input bit bst, input bit ie);
    @(negedge clk);
    src_addr_i = AW'(src); dst_addr_i = AW'(dst); count_i = CW'(cnt);
    src_mode_i = 2'(sm); dst_mode_i = 2'(dm); unit_i = 2'(un);
    burst_i = bst; irq_en_i = ie; load_i = 1;
    @(negedge clk);
    load_i = 0;
  endtask

  task automatic clear_end();
    @(negedge clk);
    end_clr_i = 1;
    @(negedge clk);
    end_clr_i = 0;
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (!end_flag_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(end_flag_o == 1'b1, req, "end flag after run", end_flag_o, 1);
  endtask

  task automatic start_run();
    @(negedge clk);
    #1 log_n = 0; drops = 0;
    enable_i = 1;
  endtask

  task automatic verify(input int src, input int dst, input int cnt, input int sm,
                        input int dm, input int un, input bit bst, input bit ie);
    int n  = (cnt == 0) ? (1 << CW) : cnt;
    int ub = (un == 3) ? 16 : (1 << un);
    int nb = (un == 3) ? 4 : 1;
    int ds = (sm == 1) ? 1 : (sm == 2) ? -1 : 0;
    int dd = (dm == 1) ? 1 : (dm == 2) ? -1 : 0;
    int esz = (un == 3) ? 2 : un;
    int aerr = 0, derr = 0, serr = 0;
    chk(log_n == 2 * n * nb, "R3", "beat count", log_n, 2 * n * nb);
    for (int u = 0; u < n; u++) begin
      for (int k = 0; k < nb; k++) begin
        int ri = u * 2 * nb + k;
        int wi = ri + nb;
        logic [15:0] ea_s = 16'(src + ds * ub * u + 4 * k);
        logic [15:0] ea_d = 16'(dst + dd * ub * u + 4 * k);
        if (wi < 64) begin
          if (log_addr[ri] != ea_s || log_wr[ri] || log_addr[wi] != ea_d || !log_wr[wi]) aerr++;
          if (log_data[wi] != log_data[ri]) derr++;
          if (log_size[ri] != 2'(esz) || log_size[wi] != 2'(esz)) serr++;
        end
      end
    end
    chk(aerr == 0, "R4", "address/direction mismatches", aerr, 0);
    chk(derr == 0, "R3", "write data mismatches", derr, 0);
    chk(serr == 0, "R5", "beat size mismatches", serr, 0);
    if (bst) chk(drops == 0, "R8", "bus releases in burst", drops, 0);
    else     chk(drops == n - 1, "R7", "bus releases in cycle-steal", drops, n - 1);
    chk(irq_o == ie, "R9", "irq follows enable", irq_o, ie);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5C3_0000 ^ (i * 32'h0101_0137);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req_o && !mem_valid_o, "R1", "bus idle after reset", {bus_req_o, mem_valid_o}, 0);
    chk(!end_flag_o && !irq_o, "R1", "flags low after reset", {end_flag_o, irq_o}, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      int sm = VEC[v][11:10], dm = VEC[v][9:8], un = VEC[v][7:6];
      bit bst = VEC[v][5], ie = VEC[v][4];
      int cnt = VEC[v][3:0];
      load_cfg(16'h0100, 16'h0300, cnt, sm, dm, un, bst, ie);
      clear_end();
      start_run();
      wait_end("R9");
      enable_i = 0;
      verify(16'h0100, 16'h0300, cnt, sm, dm, un, bst, ie);
    end

    // R6 loaded zero means 2^CW transfers
    load_cfg(16'h0040, 16'h0200, 0, 1, 1, 0, 1'b0, 1'b1);
    clear_end();
    start_run();
    wait_end("R6");
    enable_i = 0;
    chk(log_n == 2 * (1 << CW), "R6", "zero count beats", log_n, 2 * (1 << CW));
    chk(log_n >= 1 && log_addr[log_n - 1] == 16'h0200 + 16'((1 << CW) - 1), "R6",
        "last destination address", log_addr[log_n - 1], 16'h0200 + (1 << CW) - 1);

    // R2 no request with enable low; no access without grant
    load_cfg(16'h0100, 16'h0300, 2, 1, 1, 2, 1'b1, 1'b1);
    clear_end();
    @(negedge clk);
    #1 log_n = 0;
    repeat (5) @(negedge clk);
    chk(!bus_req_o && log_n == 0, "R2", "quiet while disabled", bus_req_o, 0);
    grant_i = 0;
    enable_i = 1;
    repeat (8) @(negedge clk);
    chk(bus_req_o == 1'b1, "R2", "request while waiting", bus_req_o, 1);
    chk(log_n == 0, "R2", "no access without grant", log_n, 0);
    grant_i = 1;
    wait_end("R2");
    chk(log_n == 4, "R2", "beats after grant", log_n, 4);

    // R10 end flag blocks restart until cleared (enable stays high)
    load_cfg(16'h0100, 16'h0300, 3, 1, 1, 2, 1'b0, 1'b0);
    @(negedge clk);
    #1 log_n = 0;
    repeat (10) @(negedge clk);
    chk(log_n == 0 && !bus_req_o, "R10", "blocked while end set", log_n, 0);
    clear_end();
    wait_end("R10");
    enable_i = 0;
    chk(log_n == 6, "R10", "runs after clear", log_n, 6);
    chk(irq_o == 1'b0, "R9", "irq off when disabled", irq_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    bad++;
    total++;
    $display("FAIL watchdog all-reqs actual=%0d expected<100000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule